// File: doc/BRIEF.md
# Serial Byte Host Port with Chip Addressing

This block is the device side of a byte-oriented serial link between a host processor and a peripheral core. The host selects the device with an active-low select, clocks it with an active-low serial clock and moves data on a single serial line. Bits go most significant first in both directions. After every eighth serial clock rising edge inside a selected frame, the port hands the finished byte to the core with a one-cycle valid pulse. It then holds its active-low busy output low until the core reports that it has finished.

Chip addressing is an optional mode for several devices that share one select. When it is on, the first byte of each frame is an address. The port compares the low two bits of that byte with a static device address. On a match, the rest of the frame is served as usual. On a mismatch, the port stays silent until select is released. All external pins are brought into the system clock domain through two-flop synchronizers, and edges are detected there. The bidirectional line is split into input, output and output-enable.

Top module: `sbyte_host_port`

## Requirements
- R1: A byte completes on the eighth serial clock rising edge (`sckN` going 0 to 1) counted while `csN` is low. The port then raises `rxValid` for exactly one clock with the byte on `rxByte`.
- R2: A partial byte is discarded when `csN` goes high or `rst` is asserted. The next byte counts its bits from zero.
- R3: Input bits are sampled on serial clock rising edges, and the first bit becomes `rxByte[7]`.
- R4: `busyN` goes low when a data byte completes. It stays low until `coreDone` is pulsed, and goes high again after that.
- R5: In a served frame with `rdMode` high, `txData` is sent most significant bit first. Each bit is placed on `sdOut` at a serial clock falling edge, and `sdOe` is high only while `csN` is low.
- R6: With `addrModeEn` high, the first byte after `csN` falls is an address. Only its bits [1:0] are compared with `devAddr`. The address byte gives no `rxValid` and leaves `busyN` high. On a match, later bytes are served.
- R7: On an address mismatch, later bytes in the frame give no `rxValid`, no busy and no drive on `sdOe`. A new frame starts with a fresh address byte.
- R8: With `addrModeEn` low, the first byte of a frame is already data.
- R9: After reset, `busyN` is high, `rxValid` is low and `sdOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset |
| csN | input | 1 | Active-low chip select from host |
| sckN | input | 1 | Active-low serial clock from host |
| sdIn | input | 1 | Serial data line, input side |
| sdOut | output | 1 | Serial data line, output side |
| sdOe | output | 1 | Output enable for the serial data line |
| busyN | output | 1 | Active-low busy to host |
| addrModeEn | input | 1 | Enables the leading address byte |
| devAddr | input | 2 | Static device address |
| rdMode | input | 1 | Core asks for the next bytes to be sent to host |
| txData | input | 8 | Byte to send to host |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse per received data byte |
| coreDone | input | 1 | Core signals that processing is complete |

## Verification
Writes use the patterns A5, 3C, 81 and 42. These asymmetric values show up bit-order swaps and shift-by-one errors. A byte cut short by select release, and another cut short by reset, each precede a full byte. Any bits left in the counter would then corrupt the following value. Reads send C6 and then 39 in one frame, which checks both the load at the start of each byte and the MSB-first order. In addressed frames, FE matches only through its low two bits, 01 is a mismatch, and a fresh frame after the mismatch must be served again.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  typedef struct packed {
    logic clrCnt;
    logic sampleBit;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/sbp_sync.sv
`timescale 1ns/1ps
module sbp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] stage [STAGES];
  logic [WIDTH-1:0] prevLvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
      prevLvl <= RESET_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      prevLvl <= stage[STAGES-1];
    end
  end

  assign syncOut = stage[STAGES-1];

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise[b] = stage[STAGES-1][b] & ~prevLvl[b];
    assign fall[b] = ~stage[STAGES-1][b] & prevLvl[b];
  end
endmodule

// File: rtl/sbp_dpath.sv
`timescale 1ns/1ps
module sbp_dpath
  import sbp_pkg::*;
#(
  parameter int WIDTH = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        stb,
  input  logic             sdBit,
  input  logic [WIDTH-1:0] txData,
  output logic [WIDTH-1:0] rxShift,
  output logic [1:0]       addrLow,
  output logic             lastBit,
  output logic             cntZero,
  output logic             txBit
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [WIDTH-1:0] txShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (stb.clrCnt) begin
        bitCnt <= '0;
      end else if (stb.sampleBit) begin
        bitCnt  <= lastBit ? '0 : bitCnt + 1'b1;
        rxShift <= {rxShift[WIDTH-2:0], sdBit};
      end
      if (stb.loadTx)       txShift <= txData;
      else if (stb.shiftTx) txShift <= {txShift[WIDTH-2:0], 1'b0};
    end
  end

  assign lastBit = (bitCnt == CNT_LAST);
  assign cntZero = (bitCnt == '0);
  assign txBit   = txShift[WIDTH-1];
  assign addrLow = {rxShift[0], sdBit};

  a_r2_count_cleared: assert property (@(posedge clk) disable iff (rst)
    stb.clrCnt |=> cntZero);
  a_r3_msb_first_shift: assert property (@(posedge clk) disable iff (rst)
    (stb.sampleBit && !stb.clrCnt) |=> rxShift[0] == $past(sdBit));
endmodule

// File: rtl/sbp_ctrl.sv
`timescale 1ns/1ps
module sbp_ctrl
  import sbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csHigh,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              addrModeEn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              rdMode,
  input  logic              coreDone,
  input  logic              cntZero,
  input  logic              lastBit,
  input  logic [1:0]        addrLow,
  output dpStrobe_t         stb,
  output logic              rxValid,
  output logic              busy,
  output logic              sdOe
);
  logic addrPhase;
  logic blocked;
  logic active;
  logic byteEnd;

  assign active  = ~csHigh & ~busy & ~blocked;
  assign byteEnd = stb.sampleBit & lastBit;

  always_comb begin
    stb.clrCnt    = csHigh;
    stb.sampleBit = sckRise & active;
    stb.loadTx    = sckFall & active & cntZero;
    stb.shiftTx   = sckFall & active & ~cntZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrPhase <= 1'b0;
      blocked   <= 1'b0;
      busy      <= 1'b0;
      rxValid   <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (busy && coreDone) busy <= 1'b0;
      if (csHigh) begin
        addrPhase <= addrModeEn;
        blocked   <= 1'b0;
      end else if (byteEnd) begin
        if (addrPhase) begin
          addrPhase <= 1'b0;
          blocked   <= (addrLow != devAddr);
        end else begin
          busy    <= 1'b1;
          rxValid <= 1'b1;
        end
      end
    end
  end

  assign sdOe = ~csHigh & ~blocked & ~addrPhase & rdMode;

  a_r4_busy_held: assert property (@(posedge clk) disable iff (rst)
    (busy && !coreDone) |=> busy);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);
  a_r7_blocked_silent: assert property (@(posedge clk) disable iff (rst)
    blocked |=> !rxValid);
  a_r6_addr_no_busy: assert property (@(posedge clk) disable iff (rst)
    (addrPhase && !busy) |=> !busy);
endmodule

// File: rtl/sbyte_host_port.sv
`timescale 1ns/1ps
module sbyte_host_port
  import sbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              sckN,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic              busyN,
  input  logic              addrModeEn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              rdMode,
  input  logic [BYTE_W-1:0] txData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  input  logic              coreDone
);
  logic [2:0] pinSync, pinRise, pinFall;
  dpStrobe_t  stb;
  logic       lastBit, cntZero, busy;
  logic [1:0] addrLow;

  sbp_sync #(.WIDTH(3), .STAGES(2), .RESET_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .asyncIn({csN, sckN, sdIn}),
    .syncOut(pinSync), .rise(pinRise), .fall(pinFall)
  );

  sbp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csHigh(pinSync[2]),
    .sckRise(pinRise[1]), .sckFall(pinFall[1]),
    .addrModeEn(addrModeEn), .devAddr(devAddr), .rdMode(rdMode),
    .coreDone(coreDone), .cntZero(cntZero), .lastBit(lastBit),
    .addrLow(addrLow), .stb(stb), .rxValid(rxValid), .busy(busy),
    .sdOe(sdOe)
  );

  sbp_dpath #(.WIDTH(BYTE_W)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .sdBit(pinSync[0]),
    .txData(txData), .rxShift(rxByte), .addrLow(addrLow),
    .lastBit(lastBit), .cntZero(cntZero), .txBit(sdOut)
  );

  assign busyN = ~busy;

  a_r9_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (busyN && !rxValid));
endmodule

// File: tb/sim_sbyte_host_port.sv
`timescale 1ns/1ps
module sim_sbyte_host_port;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, sckN = 1'b1, sdIn = 1'b0;
  logic sdOut, sdOe, busyN, rxValid;
  logic addrModeEn = 1'b0;
  logic [1:0] devAddr = 2'b00;
  logic rdMode = 1'b0;
  logic [7:0] txData = 8'h00;
  logic [7:0] rxByte;
  logic coreDone = 1'b0;

  int checks = 0, failures = 0, vCount = 0;
  logic [7:0] lastRx = 8'h00;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  sbyte_host_port u0 (
    .clk(clk), .rst(rst), .csN(csN), .sckN(sckN), .sdIn(sdIn),
    .sdOut(sdOut), .sdOe(sdOe), .busyN(busyN), .addrModeEn(addrModeEn),
    .devAddr(devAddr), .rdMode(rdMode), .txData(txData), .rxByte(rxByte),
    .rxValid(rxValid), .coreDone(coreDone)
  );

  always @(negedge clk) if (rxValid) begin
    vCount++;
    lastRx = rxByte;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, output logic [7:0] rd);
    rd = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      sckN = 1'b0; sdIn = b[i];
      waitCyc(HALF);
      rd[i] = sdOut;
      sckN = 1'b1;
      waitCyc(HALF);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic [7:0] rd);
    sendBits(b, 8, rd);
    waitCyc(4);
  endtask

  task automatic ackCore();
    coreDone = 1'b1; waitCyc(1); coreDone = 1'b0; waitCyc(3);
    check(busyN == 1'b1, "R4 busy released", busyN, 1);
  endtask

  task automatic testReset();
    check(busyN == 1'b1, "R9 busyN", busyN, 1);
    check(rxValid == 1'b0, "R9 rxValid", rxValid, 0);
    check(sdOe == 1'b0, "R9 sdOe", sdOe, 0);
  endtask

  task automatic testWrite(input logic [7:0] b);
    logic [7:0] rd;
    int v0;
    csN = 1'b0; waitCyc(6);
    v0 = vCount;
    sendByte(b, rd);
    check(vCount == v0 + 1, "R1 R8 one pulse", vCount - v0, 1);
    check(lastRx == b, "R3 byte value", lastRx, b);
    check(busyN == 1'b0, "R4 busy low", busyN, 0);
    waitCyc(20);
    check(busyN == 1'b0, "R4 busy held", busyN, 0);
    ackCore();
    csN = 1'b1; waitCyc(6);
  endtask

  task automatic testAbort();
    logic [7:0] rd;
    int v0;
    v0 = vCount;
    csN = 1'b0; waitCyc(6);
    sendBits(8'hF0, 4, rd);
    csN = 1'b1; waitCyc(8);
    check(vCount == v0 && busyN, "R2 partial dropped", vCount - v0, 0);
    csN = 1'b0; waitCyc(6);
    sendByte(8'h81, rd);
    check(lastRx == 8'h81 && vCount == v0 + 1, "R2 after select drop", lastRx, 8'h81);
    ackCore();
    sendBits(8'hE0, 3, rd);
    rst = 1'b1; waitCyc(3); rst = 1'b0; waitCyc(6);
    sendByte(8'h42, rd);
    check(lastRx == 8'h42, "R2 after reset", lastRx, 8'h42);
    ackCore();
    csN = 1'b1; waitCyc(6);
  endtask

  task automatic testRead();
    logic [7:0] rd;
    rdMode = 1'b1; txData = 8'hC6;
    csN = 1'b0; waitCyc(6);
    check(sdOe == 1'b1, "R5 drive on", sdOe, 1);
    sendByte(8'h00, rd);
    check(rd == 8'hC6, "R5 first read", rd, 8'hC6);
    txData = 8'h39;
    ackCore();
    sendByte(8'h00, rd);
    check(rd == 8'h39, "R5 second read", rd, 8'h39);
    ackCore();
    csN = 1'b1; waitCyc(6);
    check(sdOe == 1'b0, "R5 drive off", sdOe, 0);
    rdMode = 1'b0;
  endtask

  task automatic testAddrMatch();
    logic [7:0] rd;
    int v0;
    addrModeEn = 1'b1; devAddr = 2'b10; waitCyc(4);
    csN = 1'b0; waitCyc(6);
    v0 = vCount;
    sendByte(8'hFE, rd);
    check(vCount == v0, "R6 no pulse for address", vCount - v0, 0);
    check(busyN == 1'b1, "R6 no busy for address", busyN, 1);
    sendByte(8'h5A, rd);
    check(vCount == v0 + 1 && lastRx == 8'h5A, "R6 data after match", lastRx, 8'h5A);
    ackCore();
    csN = 1'b1; waitCyc(6);
  endtask

  task automatic testAddrMiss();
    logic [7:0] rd;
    int v0;
    rdMode = 1'b1; txData = 8'hAA;
    csN = 1'b0; waitCyc(6);
    check(sdOe == 1'b0, "R5 no drive during address", sdOe, 0);
    v0 = vCount;
    sendByte(8'h01, rd);
    sendByte(8'h77, rd);
    check(vCount == v0, "R7 ignored data", vCount - v0, 0);
    check(busyN == 1'b1, "R7 no busy", busyN, 1);
    check(sdOe == 1'b0, "R7 no drive", sdOe, 0);
    csN = 1'b1; waitCyc(6);
    rdMode = 1'b0;
    csN = 1'b0; waitCyc(6);
    sendByte(8'h02, rd);
    sendByte(8'h66, rd);
    check(vCount == v0 + 1 && lastRx == 8'h66, "R7 new frame served", lastRx, 8'h66);
    ackCore();
    csN = 1'b1; waitCyc(6);
    addrModeEn = 1'b0;
  endtask

  initial begin
    waitCyc(5);
    rst = 1'b0;
    waitCyc(5);
    testReset();
    testWrite(8'hA5);
    testWrite(8'h3C);
    testAbort();
    testRead();
    testAddrMatch();
    testAddrMiss();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule